// File: doc/BRIEF.md
# Programmable Interval Timer Prescaler

This block is a free-running interval timer built around a binary ripple-free divider of fourteen stages. The divider advances either on every system clock enable or on every rising edge of a slow subsystem clock, and a 4-bit interval code chooses which divider stage becomes the timer tap. That tap is handed to neighbouring peripherals as a prescaler clock after passing through a two-flop resynchroniser that advances with the system clock. The same tap drives the timer interrupt.

The timer needs no software setup: it counts straight out of reset. Software can change the interval code, choose the divider clock source, route the subsystem clock around the divider, and mask the interrupt. A restart request clears the divider, but only while the external watchdog reports itself disabled. While the chip sleeps with its system clock stopped, the prescaler output is forced low at once. The divider and the interrupt logic keep running from the subsystem clock during that time.

Everything is clocked by one always-running base clock `clk`. The system clock appears as the enable `sys_ce`, and the subsystem clock as the sampled level `sub_clk`, which must be synchronous to `clk`.

Top module: `ivt_top`

## Requirements
- R1: After reset, `tmr_out` and `irq` are 0. With no configuration write, the divider counts rising edges of `sub_clk` using interval code 0.
- R2: Interval codes 0 to 13 make the tap period 2^(code+1) divider clock events. Code 0 gives divide-by-2 and code 13 gives divide-by-16384.
- R3: Interval codes 14 and 15 select the longest interval, divide-by-16384.
- R4: With `ctl_src_sys`=1 the divider advances once per cycle with `sys_ce`=1. With 0 it advances once per rising edge of `sub_clk`. Otherwise the count holds.
- R5: With `ctl_bypass`=1 the tap is the sampled `sub_clk` level, so `tmr_out` has the period of `sub_clk`.
- R6: The tap reaches `tmr_out` through two flops that load only in cycles with `sys_ce`=1. While `sys_ce` stays 0, `tmr_out` holds.
- R7: `sleep`=1 forces `tmr_out` to 0 in the same cycle, without waiting for the resynchroniser.
- R8: In sleep, with `sys_ce` at 0, the divider keeps counting from `sub_clk` and still raises the interrupt.
- R9: Each rising edge of the tap sets a sticky pending flag. An `irq_ack` pulse clears it. A new tap edge in the same cycle as an acknowledge wins.
- R10: `irq` is the pending flag gated by the mask bit. Clearing the mask hides the flag but does not clear it.
- R11: A `cfg_wr` with `cfg_restart`=1 while `wdt_en`=0 clears the divider. After interval code 13 is written this way, `tmr_out` first rises 8194 cycles later when `sys_ce` is held at 1.
- R12: A `cfg_wr` with `cfg_restart`=1 while `wdt_en`=1 still loads the interval code but leaves the divider count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_ce | input | 1 | System clock enable; 0 while the system oscillator is stopped |
| sub_clk | input | 1 | Slow subsystem clock level, synchronous to `clk` |
| sleep | input | 1 | Sleep indication; gates `tmr_out` low |
| wdt_en | input | 1 | Watchdog active; blocks divider restart |
| cfg_wr | input | 1 | Interval register write strobe |
| cfg_sel | input | 4 | Interval code |
| cfg_restart | input | 1 | Restart request carried with `cfg_wr` |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_src_sys | input | 1 | Divider clock source: 1 system, 0 subsystem |
| ctl_bypass | input | 1 | Route `sub_clk` around the divider |
| ctl_irq_en | input | 1 | Interrupt mask bit, 1 enables |
| irq_ack | input | 1 | Clears the pending flag |
| tmr_out | output | 1 | Resynchronised prescaler output |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench uses the default fourteen stages, so the longest tap, divide-by-16384, is measured as a full period in system-clock mode. This also confirms that codes 14 and 15 fall back to it. Because the divider is that long, a restart made about 8000 cycles into a count tells a cleared divider (next rise roughly 8194 cycles away) from an untouched one (next rise within a few hundred cycles). In subsystem mode, `sub_clk` toggles every four cycles, which exercises counting, bypass and sleep activity at a rate well apart from that of `sys_ce`.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    parameter int IVT_SEL_W = 4;

    typedef struct packed {
        logic [IVT_SEL_W-1:0] sel;
        logic                 src_sys;
        logic                 bypass;
        logic                 irq_en;
    } ivt_ctl_t;

endpackage

// File: rtl/ivt_divider.sv
module ivt_divider #(
    parameter int STAGES = 14,
    parameter int SEL_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sub_clk,
    input  logic             sys_ce,
    input  logic             src_sys,
    input  logic             bypass,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             tap
);
    localparam int IDX_W = (STAGES > 1) ? $clog2(STAGES) : 1;

    typedef struct packed {
        logic [STAGES-1:0] cnt;
        logic              sub_s1;
        logic              sub_s2;
    } div_state_t;

    div_state_t state_q, state_d;
    logic             step;
    logic [IDX_W-1:0] tap_idx;

    always_comb begin
        state_d        = state_q;
        state_d.sub_s1 = sub_clk;
        state_d.sub_s2 = state_q.sub_s1;
        step = src_sys ? sys_ce : (state_q.sub_s1 & ~state_q.sub_s2);
        if (restart) begin
            state_d.cnt = '0;
        end else if (step) begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
        tap_idx = (int'(sel) >= STAGES) ? IDX_W'(STAGES - 1) : IDX_W'(sel);
        tap     = bypass ? state_q.sub_s1 : state_q.cnt[tap_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assert_restart_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state_q.cnt == '0));

    assert_hold_without_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !step) |=> $stable(state_q.cnt));

endmodule

// File: rtl/ivt_irq.sv
module ivt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic tap,
    input  logic ack,
    output logic pend
);
    typedef struct packed {
        logic tap_prev;
        logic pend;
    } irq_state_t;

    irq_state_t state_q, state_d;
    logic       tap_rise;

    always_comb begin
        state_d          = state_q;
        state_d.tap_prev = tap;
        tap_rise         = tap & ~state_q.tap_prev;
        state_d.pend     = tap_rise | (state_q.pend & ~ack);
        pend             = state_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !ack) |=> pend);

    assert_pend_clear_by_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> $past(ack));

endmodule

// File: rtl/ivt_sync.sv
module ivt_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_ce,
    input  logic sleep,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_state_t;

    sync_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (sys_ce) begin
            state_d.s1 = din;
            state_d.s2 = state_q.s1;
        end
        dout = state_q.s2 & ~sleep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assert_moves_on_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_ce |=> $stable(state_q.s2));

endmodule

// File: rtl/ivt_top.sv
module ivt_top
    import ivt_pkg::*;
#(
    parameter int STAGES  = 14,
    parameter int RST_SEL = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sys_ce,
    input  logic                 sub_clk,
    input  logic                 sleep,
    input  logic                 wdt_en,
    input  logic                 cfg_wr,
    input  logic [IVT_SEL_W-1:0] cfg_sel,
    input  logic                 cfg_restart,
    input  logic                 ctl_wr,
    input  logic                 ctl_src_sys,
    input  logic                 ctl_bypass,
    input  logic                 ctl_irq_en,
    input  logic                 irq_ack,
    output logic                 tmr_out,
    output logic                 irq
);
    localparam ivt_ctl_t CTL_RST = '{sel: IVT_SEL_W'(RST_SEL), src_sys: 1'b0,
                                     bypass: 1'b0, irq_en: 1'b0};

    ivt_ctl_t ctl_q, ctl_d;
    logic     restart_go;
    logic     tap;
    logic     pend;

    always_comb begin
        ctl_d = ctl_q;
        if (cfg_wr) begin
            ctl_d.sel = cfg_sel;
        end
        if (ctl_wr) begin
            ctl_d.src_sys = ctl_src_sys;
            ctl_d.bypass  = ctl_bypass;
            ctl_d.irq_en  = ctl_irq_en;
        end
        restart_go = cfg_wr & cfg_restart & ~wdt_en;
        irq        = pend & ctl_q.irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    ivt_divider #(
        .STAGES (STAGES),
        .SEL_W  (IVT_SEL_W)
    ) i_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .sub_clk (sub_clk),
        .sys_ce  (sys_ce),
        .src_sys (ctl_q.src_sys),
        .bypass  (ctl_q.bypass),
        .sel     (ctl_q.sel),
        .restart (restart_go),
        .tap     (tap)
    );

    ivt_irq i_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .tap   (tap),
        .ack   (irq_ack),
        .pend  (pend)
    );

    ivt_sync i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sys_ce (sys_ce),
        .sleep  (sleep),
        .din    (tap),
        .dout   (tmr_out)
    );

    assert_sleep_forces_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !tmr_out);

    assert_mask_blocks_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.irq_en |-> !irq);

endmodule

// File: tb/test_ivt_top.sv
module test_ivt_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_ce = 1'b1;
    logic       sub_clk = 1'b0;
    logic       sleep = 1'b0;
    logic       wdt_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_sel = 4'd0;
    logic       cfg_restart = 1'b0;
    logic       ctl_wr = 1'b0;
    logic       ctl_src_sys = 1'b0;
    logic       ctl_bypass = 1'b0;
    logic       ctl_irq_en = 1'b0;
    logic       irq_ack = 1'b0;
    logic       tmr_out;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam int NV = 7;
    localparam logic [3:0] V_SEL [NV] = '{4'd0, 4'd1, 4'd3, 4'd7, 4'd13, 4'd14, 4'd15};
    localparam int         V_PER [NV] = '{2, 4, 16, 256, 16384, 16384, 16384};

    always #4 clk = ~clk;

    int sub_cnt = 0;
    always @(negedge clk) begin
        sub_cnt <= (sub_cnt == 3) ? 0 : sub_cnt + 1;
        if (sub_cnt == 3) sub_clk <= ~sub_clk;
    end

    ivt_top i_ivt_top (
        .clk(clk), .rst_n(rst_n), .sys_ce(sys_ce), .sub_clk(sub_clk), .sleep(sleep),
        .wdt_en(wdt_en), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_restart(cfg_restart),
        .ctl_wr(ctl_wr), .ctl_src_sys(ctl_src_sys), .ctl_bypass(ctl_bypass),
        .ctl_irq_en(ctl_irq_en), .irq_ack(irq_ack), .tmr_out(tmr_out), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] sel, input logic rs);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_restart = rs;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_restart = 1'b0;
    endtask

    task automatic ctl_write(input logic src, input logic byp, input logic en);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_src_sys = src; ctl_bypass = byp; ctl_irq_en = en;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    // Cycles between two consecutive rising edges of tmr_out, sampled at negedges.
    task automatic measure_period(output int per);
        logic prev;
        int   guard;
        per = -1;
        prev = tmr_out;
        guard = 0;
        while (!(tmr_out && !prev) && guard < 40000) begin
            prev = tmr_out; @(negedge clk); guard++;
        end
        per = 0;
        prev = tmr_out;
        while (guard < 40000) begin
            @(negedge clk); per++; guard++;
            if (tmr_out && !prev) break;
            prev = tmr_out;
        end
        if (guard >= 40000) per = -1;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int per;
        int bad_cnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tmr_out == 1'b0, "R1", "tmr_out in reset", tmr_out, 0);
        check(irq == 1'b0, "R1", "irq in reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tmr_out == 1'b0 && irq == 1'b0, "R1", "outputs after reset", {tmr_out, irq}, 0);
        // R1/R4: runs from sub_clk at code 0 with no writes; sub period 8 -> 16
        measure_period(per);
        check(per == 16, "R1", "auto-run period from sub_clk", per, 16);

        // R2/R3: interval table in system clock mode
        ctl_write(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < NV; i++) begin
            cfg_write(V_SEL[i], 1'b1);
            measure_period(per);
            check(per == V_PER[i], (V_SEL[i] > 13) ? "R3" : "R2", "tap period", per, V_PER[i]);
        end

        // R4: subsystem source, code 2 -> 8 sub periods = 64 cycles
        ctl_write(1'b0, 1'b0, 1'b0);
        cfg_write(4'd2, 1'b1);
        measure_period(per);
        check(per == 64, "R4", "sub source code 2 period", per, 64);

        // R5: bypass follows sub_clk period of 8
        ctl_write(1'b1, 1'b1, 1'b0);
        measure_period(per);
        check(per == 8, "R5", "bypass period", per, 8);

        // R6: output holds while sys_ce is 0 even though divider runs from sub_clk
        ctl_write(1'b0, 1'b0, 1'b1);
        cfg_write(4'd0, 1'b1);
        @(negedge clk);
        sys_ce = 1'b0;
        @(negedge clk);
        per = tmr_out;
        ack_pulse();
        bad_cnt = 0;
        repeat (60) begin
            @(negedge clk);
            if (tmr_out !== per[0]) bad_cnt++;
        end
        check(bad_cnt == 0, "R6", "tmr_out changes while sys_ce low", bad_cnt, 0);
        check(irq == 1'b1, "R6", "divider active behind frozen output", irq, 1);
        sys_ce = 1'b1;
        measure_period(per);
        check(per == 16, "R6", "period after sys_ce resumes", per, 16);

        // R7: sleep gates a high output in the same cycle
        ctl_write(1'b1, 1'b0, 1'b1);
        cfg_write(4'd3, 1'b1);
        while (tmr_out !== 1'b1) @(negedge clk);
        sleep = 1'b1;
        #1;
        check(tmr_out == 1'b0, "R7", "tmr_out same cycle as sleep", tmr_out, 0);

        // R8: sleep with system clock stopped, divider on sub_clk still interrupts
        sys_ce = 1'b0;
        ctl_write(1'b0, 1'b0, 1'b1);
        cfg_write(4'd2, 1'b1);
        ack_pulse();
        bad_cnt = 0;
        repeat (150) begin
            @(negedge clk);
            if (tmr_out !== 1'b0) bad_cnt++;
        end
        check(irq == 1'b1, "R8", "irq raised in sleep", irq, 1);
        check(bad_cnt == 0, "R7", "tmr_out high during sleep", bad_cnt, 0);
        sleep = 1'b0;
        sys_ce = 1'b1;

        // R10: mask hides pending, unmask reveals it
        ctl_write(1'b1, 1'b0, 1'b0);
        cfg_write(4'd0, 1'b1);
        repeat (10) @(negedge clk);
        check(irq == 1'b0, "R10", "irq while masked", irq, 0);
        ctl_write(1'b1, 1'b0, 1'b1);
        check(irq == 1'b1, "R10", "pending kept under mask", irq, 1);

        // R9: acknowledge clears, next tap edge sets again
        cfg_write(4'd13, 1'b1);
        ack_pulse();
        check(irq == 1'b0, "R9", "irq after ack", irq, 0);
        repeat (100) @(negedge clk);
        check(irq == 1'b0, "R9", "irq stays clear without tap edge", irq, 0);
        repeat (8200) @(negedge clk);
        check(irq == 1'b1, "R9", "irq set by tap edge", irq, 1);

        // R11: restart clears divider; first rise 8194 cycles later
        cfg_write(4'd13, 1'b1);
        repeat (8000) @(negedge clk);
        check(tmr_out == 1'b0, "R11", "tmr_out before 8194 after restart", tmr_out, 0);
        repeat (300) @(negedge clk);
        check(tmr_out == 1'b1, "R11", "tmr_out after restart interval", tmr_out, 1);

        // R12: restart blocked by watchdog, code still loaded
        cfg_write(4'd13, 1'b1);
        repeat (8000) @(negedge clk);
        wdt_en = 1'b1;
        cfg_write(4'd13, 1'b1);
        repeat (300) @(negedge clk);
        check(tmr_out == 1'b1, "R12", "count kept under watchdog", tmr_out, 1);
        cfg_write(4'd0, 1'b1);
        measure_period(per);
        check(per == 2, "R12", "code loaded under watchdog", per, 2);
        wdt_en = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule